// File: doc/BRIEF.md
# Chipset Interrupt Routing Bridge

This block steers level-sensitive interrupt requests from three groups of sources onto sixteen legacy interrupt-controller input lines. The groups are eight on-chip device requests, four shared PCI interrupt lines (A to D) and two ACPI event sources. Each source has its own target field in a small byte-addressable configuration space. A field holding zero turns its source off. A field naming a line at or beyond the sixteenth is discarded. Any line that more than one live source selects carries the OR of those sources.

On the device side, index 0 to 4 of the on-chip request vector belong to device slots 2 to 6 in order, and index 6 belongs to slot 9. The graphics bridge drives shared line C. The block also holds a boot ROM enable. A two-state machine with states ROM_LIVE and ROM_SHUT controls it. Reset enters ROM_LIVE. The single transition, the shut-off write, moves to ROM_SHUT, and only another reset leaves that state.

The configuration port takes a dword index, a 32-bit data word and four byte enables. Writes take effect at the clock edge. Reads are registered.

Top module: `irq_route_bridge`

## Requirements
- R1: Reset clears every routing register to zero, holds every interrupt output low with all sources active, and sets the boot ROM enable to 1.
- R2: On-chip request n is routed by the 4-bit field at bits [4n+3:4n] of the dword at byte offset 0x6C (index 0x1B). A field value t of 1 to 15 drives output line t while the request is high.
- R3: An on-chip request whose 4-bit field is 0 reaches no output. Output line 0 is therefore never driven by any source.
- R4: Shared PCI line n (0 = A to 3 = D) is routed by the byte at byte offset 0x68+n, which is bits [8n+7:8n] of the dword at index 0x1A. A value of 1 to 15 drives that output line.
- R5: ACPI source k (0 or 1) is routed by bits [8k+7:8k] of the dword at byte offset 0x64 (index 0x19). A value of 0 disables that source.
- R6: An 8-bit routing value of 16 or more drives no output line.
- R7: An output line is the OR of the current levels of all enabled sources that select it.
- R8: Outputs follow source levels combinationally, with no clock delay. A routing write is in effect from the clock edge that accepts it.
- R9: A write updates only the byte lanes whose enable bit is set. The other bytes keep their value.
- R10: A read accepted at a clock edge presents the stored dword on the read data port after that edge. Reads of unmapped indexes return 0, and writes to them change nothing.
- R11: A write to byte offset 0x80 (index 0x20) with byte enable 0 set and data bit 1 set moves ROM_LIVE to ROM_SHUT and drops the boot ROM enable after that edge. A later write with bit 1 clear leaves it at 0. The dword reads back as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | 6 | Dword index (byte offset divided by 4) |
| cfg_wdata | input | 32 | Write data |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_rdata | output | 32 | Registered read data |
| dev_req | input | 8 | On-chip device interrupt levels |
| pci_req | input | 4 | Shared PCI interrupt levels A to D |
| acpi_req | input | 2 | ACPI event levels |
| pic_line | output | 16 | Interrupt-controller input lines |
| boot_rom_en | output | 1 | Boot ROM enable |

## Verification
Interrupt outputs have zero latency. A level change is therefore checked late in the same clock phase in which it is driven, before the next rising edge. Routing writes, the ROM shut-off and read data all land one rising edge after the strobe. For these, the driver pushes the expected item only once that edge has passed, and the monitor compares it late in the following low phase. This keeps every sample clear of the edge at which it changes.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;

    localparam int DEF_DEV_SRCS  = 8;
    localparam int DEF_PCI_SRCS  = 4;
    localparam int DEF_ACPI_SRCS = 2;
    localparam int DEF_LINES     = 16;
    localparam int DEV_SEL_W     = 4;
    localparam int BYTE_SEL_W    = 8;
    localparam int CFG_DW        = 32;
    localparam int CFG_AW        = 6;
    localparam int CFG_LANES     = CFG_DW / 8;
    localparam int NUM_CFG_REGS  = 4;

    // dword indexes of the routing and control words
    localparam logic [CFG_AW-1:0] IDX_ACPI = 6'h19;
    localparam logic [CFG_AW-1:0] IDX_PCI  = 6'h1A;
    localparam logic [CFG_AW-1:0] IDX_DEV  = 6'h1B;
    localparam logic [CFG_AW-1:0] IDX_ROM  = 6'h20;

    typedef enum logic [1:0] {
        SLOT_ACPI = 2'd0,
        SLOT_PCI  = 2'd1,
        SLOT_DEV  = 2'd2,
        SLOT_ROM  = 2'd3
    } reg_slot_t;

    typedef struct packed {
        logic      valid;
        reg_slot_t slot;
    } reg_hit_t;

    typedef enum logic {
        ROM_LIVE = 1'b0,
        ROM_SHUT = 1'b1
    } rom_state_t;

    function automatic reg_hit_t decode_index(input logic [CFG_AW-1:0] idx);
        reg_hit_t h;
        h.valid = 1'b1;
        h.slot  = SLOT_ACPI;
        unique case (idx)
            IDX_ACPI: h.slot = SLOT_ACPI;
            IDX_PCI:  h.slot = SLOT_PCI;
            IDX_DEV:  h.slot = SLOT_DEV;
            IDX_ROM:  h.slot = SLOT_ROM;
            default:  h.valid = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
`timescale 1ns/1ps
module irq_cfg_regs
    import irq_route_pkg::*;
#(
    parameter int ACPI_W = DEF_ACPI_SRCS * BYTE_SEL_W,
    parameter int PCI_W  = DEF_PCI_SRCS * BYTE_SEL_W,
    parameter int DEV_W  = DEF_DEV_SRCS * DEV_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [CFG_AW-1:0] idx_i,
    input  logic [CFG_DW-1:0] wdata_i,
    input  logic [CFG_LANES-1:0] be_i,
    output logic [CFG_DW-1:0] rdata_o,
    output logic [ACPI_W-1:0] acpi_sel_o,
    output logic [PCI_W-1:0]  pci_sel_o,
    output logic [DEV_W-1:0]  dev_sel_o
);

    logic [CFG_DW-1:0] regs_q [NUM_CFG_REGS];
    reg_hit_t          hit;

    assign hit = decode_index(idx_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_CFG_REGS; r++) begin
                regs_q[r] <= '0;
            end
        end else if (wr_en_i && hit.valid) begin
            for (int b = 0; b < CFG_LANES; b++) begin
                if (be_i[b]) begin
                    regs_q[hit.slot][8*b +: 8] <= wdata_i[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_en_i) begin
            rdata_o <= hit.valid ? regs_q[hit.slot] : '0;
        end
    end

    assign acpi_sel_o = regs_q[SLOT_ACPI][ACPI_W-1:0];
    assign pci_sel_o  = regs_q[SLOT_PCI][PCI_W-1:0];
    assign dev_sel_o  = regs_q[SLOT_DEV][DEV_W-1:0];

    // R9: a lane without its enable keeps its byte
    p_lane_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && idx_i == IDX_DEV && !be_i[0]) |=> dev_sel_o[7:0] == $past(dev_sel_o[7:0]));

    // R10: unmapped index reads as zero
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit.valid) |=> rdata_o == '0);

    // R10: read of the on-chip routing word returns its stored value
    p_dev_readback_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && idx_i == IDX_DEV) |=> rdata_o == $past(dev_sel_o));

endmodule

// File: rtl/irq_rom_ctl.sv
`timescale 1ns/1ps
module irq_rom_ctl
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic shut_req_i,
    output logic rom_en_o
);

    rom_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ROM_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROM_LIVE: if (shut_req_i) state_d = ROM_SHUT;
            ROM_SHUT: state_d = ROM_SHUT;
        endcase
    end

    always_comb begin
        rom_en_o = 1'b0;
        unique case (state_q)
            ROM_LIVE: rom_en_o = 1'b1;
            ROM_SHUT: rom_en_o = 1'b0;
        endcase
    end

    // R1: leaving reset the ROM is enabled
    p_rom_on_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> rom_en_o);

    // R11: a shut-off write drops the enable after its edge
    p_rom_shut_r11: assert property (@(posedge clk) disable iff (!rst_n)
        shut_req_i |=> !rom_en_o);

    // R11: once off, only reset re-enables
    p_rom_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_en_o |=> !rom_en_o);

endmodule

// File: rtl/irq_src_decode.sv
`timescale 1ns/1ps
module irq_src_decode #(
    parameter int SEL_W     = 4,
    parameter int NUM_LINES = 16
) (
    input  logic                 level_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic [NUM_LINES-1:0] hit_o
);

    // value 0 never matches (loop starts at 1); values >= NUM_LINES never match
    always_comb begin
        hit_o = '0;
        for (int i = 1; i < NUM_LINES; i++) begin
            if (level_i && (32'(sel_i) == i)) begin
                hit_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irq_route_bridge.sv
`timescale 1ns/1ps
module irq_route_bridge
    import irq_route_pkg::*;
#(
    parameter int NUM_DEV   = DEF_DEV_SRCS,
    parameter int NUM_PCI   = DEF_PCI_SRCS,
    parameter int NUM_ACPI  = DEF_ACPI_SRCS,
    parameter int NUM_LINES = DEF_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_rd_en,
    input  logic [CFG_AW-1:0]    cfg_dw_addr,
    input  logic [CFG_DW-1:0]    cfg_wdata,
    input  logic [CFG_LANES-1:0] cfg_be,
    output logic [CFG_DW-1:0]    cfg_rdata,
    input  logic [NUM_DEV-1:0]   dev_req,
    input  logic [NUM_PCI-1:0]   pci_req,
    input  logic [NUM_ACPI-1:0]  acpi_req,
    output logic [NUM_LINES-1:0] pic_line,
    output logic                 boot_rom_en
);

    localparam int DEV_W  = NUM_DEV * DEV_SEL_W;
    localparam int PCI_W  = NUM_PCI * BYTE_SEL_W;
    localparam int ACPI_W = NUM_ACPI * BYTE_SEL_W;
    localparam int LINE_W = $clog2(NUM_LINES);

    logic [DEV_W-1:0]     dev_sel;
    logic [PCI_W-1:0]     pci_sel;
    logic [ACPI_W-1:0]    acpi_sel;
    logic                 rom_shut_req;
    logic [NUM_LINES-1:0] dev_hit  [NUM_DEV];
    logic [NUM_LINES-1:0] pci_hit  [NUM_PCI];
    logic [NUM_LINES-1:0] acpi_hit [NUM_ACPI];

    irq_cfg_regs #(
        .ACPI_W (ACPI_W),
        .PCI_W  (PCI_W),
        .DEV_W  (DEV_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cfg_wr_en),
        .rd_en_i    (cfg_rd_en),
        .idx_i      (cfg_dw_addr),
        .wdata_i    (cfg_wdata),
        .be_i       (cfg_be),
        .rdata_o    (cfg_rdata),
        .acpi_sel_o (acpi_sel),
        .pci_sel_o  (pci_sel),
        .dev_sel_o  (dev_sel)
    );

    assign rom_shut_req = cfg_wr_en && (cfg_dw_addr == IDX_ROM) && cfg_be[0] && cfg_wdata[1];

    irq_rom_ctl u_rom (
        .clk        (clk),
        .rst_n      (rst_n),
        .shut_req_i (rom_shut_req),
        .rom_en_o   (boot_rom_en)
    );

    for (genvar n = 0; n < NUM_DEV; n++) begin : g_dev
        irq_src_decode #(.SEL_W(DEV_SEL_W), .NUM_LINES(NUM_LINES)) u_dec (
            .level_i (dev_req[n]),
            .sel_i   (dev_sel[DEV_SEL_W*n +: DEV_SEL_W]),
            .hit_o   (dev_hit[n])
        );

        // R3: a zero field keeps the request off every line
        p_dev_zero_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_sel[DEV_SEL_W*n +: DEV_SEL_W] == '0) |-> (dev_hit[n] == '0));

        // R2: a live request with a nonzero field reaches its line
        p_dev_reach_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (dev_req[n] && dev_sel[DEV_SEL_W*n +: DEV_SEL_W] != '0)
            |-> pic_line[dev_sel[DEV_SEL_W*n +: LINE_W]]);
    end

    for (genvar n = 0; n < NUM_PCI; n++) begin : g_pci
        irq_src_decode #(.SEL_W(BYTE_SEL_W), .NUM_LINES(NUM_LINES)) u_dec (
            .level_i (pci_req[n]),
            .sel_i   (pci_sel[BYTE_SEL_W*n +: BYTE_SEL_W]),
            .hit_o   (pci_hit[n])
        );

        // R6: out-of-range byte drives nothing
        p_pci_range_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (32'(pci_sel[BYTE_SEL_W*n +: BYTE_SEL_W]) >= NUM_LINES) |-> (pci_hit[n] == '0));

        // R4: at most one line per shared PCI source
        p_pci_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pci_hit[n]));
    end

    for (genvar k = 0; k < NUM_ACPI; k++) begin : g_acpi
        irq_src_decode #(.SEL_W(BYTE_SEL_W), .NUM_LINES(NUM_LINES)) u_dec (
            .level_i (acpi_req[k]),
            .sel_i   (acpi_sel[BYTE_SEL_W*k +: BYTE_SEL_W]),
            .hit_o   (acpi_hit[k])
        );

        // R5: a zero byte disables the ACPI source
        p_acpi_zero_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (acpi_sel[BYTE_SEL_W*k +: BYTE_SEL_W] == '0) |-> (acpi_hit[k] == '0));
    end

    always_comb begin
        pic_line = '0;
        for (int n = 0; n < NUM_DEV; n++)  pic_line |= dev_hit[n];
        for (int n = 0; n < NUM_PCI; n++)  pic_line |= pci_hit[n];
        for (int k = 0; k < NUM_ACPI; k++) pic_line |= acpi_hit[k];
    end

    // R3: line 0 can never be selected
    p_line0_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pic_line[0] == 1'b0);

    // R7: with all sources low no line is driven
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_req == '0 && pci_req == '0 && acpi_req == '0) |-> (pic_line == '0));

endmodule

// File: tb/irq_route_bridge_bench.sv
`timescale 1ns/1ps
module irq_route_bridge_bench;

    localparam int HALF = 10;

    typedef struct {
        int          kind;   // 0 lines, 1 read data, 2 rom enable
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic        cfg_rd_en = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_rdata;
    logic [7:0]  dev_req = '0;
    logic [3:0]  pci_req = '0;
    logic [1:0]  acpi_req = '0;
    logic [15:0] pic_line;
    logic        boot_rom_en;

    sb_item_t sb[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(HALF) clk = ~clk;

    irq_route_bridge u_irq_route_bridge (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_rd_en   (cfg_rd_en),
        .cfg_dw_addr (cfg_dw_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg_be      (cfg_be),
        .cfg_rdata   (cfg_rdata),
        .dev_req     (dev_req),
        .pci_req     (pci_req),
        .acpi_req    (acpi_req),
        .pic_line    (pic_line),
        .boot_rom_en (boot_rom_en)
    );

    task automatic push(input int kind, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_dw_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_rd_en = 1'b1; cfg_dw_addr = a;
        @(negedge clk);
        cfg_rd_en = 1'b0;
        push(1, exp, tag);
    endtask

    task automatic drive(input logic [7:0] d, input logic [3:0] p, input logic [1:0] a,
                         input logic [15:0] exp, input string tag);
        @(negedge clk);
        dev_req = d; pci_req = p; acpi_req = a;
        push(0, {16'h0, exp}, tag);
    endtask

    // monitor: compares late in each low phase
    initial begin
        forever begin
            @(negedge clk);
            #(HALF - 2);
            while (sb.size() > 0) begin
                sb_item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = {16'h0, pic_line};
                    1:       act = cfg_rdata;
                    default: act = {31'h0, boot_rom_en};
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        push(2, 32'h1, "R1 rom enable after reset");
        drive(8'hFF, 4'hF, 2'h3, 16'h0000, "R1 all sources off after reset");
        cfg_read(6'h1B, 32'h0, "R1 dev word reset");
        cfg_read(6'h1A, 32'h0, "R1 pci word reset");
        cfg_read(6'h19, 32'h0, "R1 acpi word reset");
        drive(8'h00, 4'h0, 2'h0, 16'h0000, "R1 idle");

        // R2/R3 on-chip routing
        cfg_write(6'h1B, 32'h1F00_A053, 4'hF);
        push(0, 32'h0, "R8 write effective, sources idle");
        drive(8'h01, 4'h0, 2'h0, 16'h0008, "R2 dev0 to line 3");
        drive(8'h02, 4'h0, 2'h0, 16'h0020, "R8 R2 dev1 to line 5 same phase");
        drive(8'h04, 4'h0, 2'h0, 16'h0000, "R3 dev2 zero field");
        drive(8'hFF, 4'h0, 2'h0, 16'h842A, "R2 all dev sources");
        drive(8'h00, 4'h0, 2'h0, 16'h0000, "R7 idle");

        // R4/R6 shared PCI routing
        cfg_write(6'h1A, 32'h200C_070B, 4'hF);
        drive(8'h00, 4'h1, 2'h0, 16'h0800, "R4 line A to 11");
        drive(8'h00, 4'h4, 2'h0, 16'h1000, "R4 line C to 12");
        drive(8'h00, 4'h8, 2'h0, 16'h0000, "R6 line D out of range");
        drive(8'h01, 4'h1, 2'h0, 16'h0808, "R7 dev and pci together");

        // R5/R6/R7 ACPI
        cfg_write(6'h19, 32'h0000_1303, 4'hF);
        drive(8'h01, 4'h0, 2'h1, 16'h0008, "R7 dev0 and acpi0 share line 3");
        drive(8'h00, 4'h0, 2'h1, 16'h0008, "R7 acpi0 alone holds line 3");
        drive(8'h00, 4'h0, 2'h2, 16'h0000, "R6 acpi1 value 19 dropped");

        // R9 byte lanes
        cfg_write(6'h19, 32'hFFFF_FF00, 4'h1);
        cfg_read(6'h19, 32'h0000_1300, "R9 only lane 0 written");
        drive(8'h00, 4'h0, 2'h1, 16'h0000, "R5 acpi0 zero disables");
        cfg_write(6'h19, 32'h0000_0900, 4'h2);
        drive(8'h00, 4'h0, 2'h2, 16'h0200, "R5 acpi1 to line 9");
        cfg_read(6'h19, 32'h0000_0900, "R9 lane 1 written");
        cfg_write(6'h1B, 32'h2000_0000, 4'h8);
        cfg_read(6'h1B, 32'h2000_A053, "R9 lane 3 only");
        drive(8'h80, 4'h0, 2'h0, 16'h0004, "R9 dev7 to line 2");
        drive(8'h40, 4'h0, 2'h0, 16'h0000, "R9 dev6 field cleared");

        // R10 unmapped
        cfg_write(6'h1C, 32'hFFFF_FFFF, 4'hF);
        cfg_read(6'h1C, 32'h0, "R10 unmapped read zero");
        cfg_read(6'h1B, 32'h2000_A053, "R10 unmapped write no effect");

        // R11 boot ROM
        cfg_write(6'h20, 32'h0000_0001, 4'hF);
        push(2, 32'h1, "R11 bit1 clear keeps rom");
        cfg_read(6'h20, 32'h0000_0001, "R11 readback");
        cfg_write(6'h20, 32'h0000_0002, 4'hF);
        push(2, 32'h0, "R11 shut-off write");
        cfg_write(6'h20, 32'h0000_0000, 4'hF);
        push(2, 32'h0, "R11 stays off");
        cfg_read(6'h20, 32'h0, "R11 readback zero");

        // R1 reset again
        @(negedge clk);
        rst_n = 1'b0;
        dev_req = '0; pci_req = '0; acpi_req = '0;
        @(negedge clk);
        rst_n = 1'b1;
        push(2, 32'h1, "R1 rom back after reset");
        cfg_read(6'h1B, 32'h0, "R1 dev word cleared");
        drive(8'hFF, 4'hF, 2'h3, 16'h0000, "R1 sources off again");

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule